// File: doc/BRIEF.md
# Serial Flash Buffer-Program Command Engine

This block is the command front end of a page-organized serial flash model. It acts as an SPI mode-0 target. Two opcodes are recognised, one for each of the two on-chip page buffers. After the opcode come three address bytes, then any number of data bytes. Each data byte goes into the chosen buffer at a running pointer. The pointer starts at the buffer offset carried in the address and wraps to zero past the last location of a page.

When chip select returns high after a complete address, the engine starts a self-timed sequence on the selected page of a small internal array. It first erases every byte of that page to 0xFF, then copies the buffer into the page. A busy output stays high for the whole sequence, and while it is high any new frame is ignored. A static input selects the page geometry: 528-byte pages in standard mode or 512-byte pages in binary mode. The two geometries lay out the address bits differently.

A peek port gives combinational read access to the array, so its contents can be observed.

Top module: `sflash_bufprog_engine`

## Requirements
- R1: After reset `busy_o` is low and no erase or program sequence runs.
- R2: Opcode 0x82 selects buffer 1 and opcode 0x85 selects buffer 2. A frame that starts with any other opcode writes no buffer and starts no sequence. The two buffers hold their contents independently.
- R3: In standard mode (`page_mode_bin`=0), the 24-bit address that follows the opcode is split as follows. Bit 23 is ignored. Bits 22..10 are the page number and bits 9..0 are the buffer start offset. The array page used is the page number modulo NUM_PAGES.
- R4: In binary mode (`page_mode_bin`=1), bits 23..22 are ignored. Bits 21..9 are the page number and bits 8..0 are the buffer start offset.
- R5: Data bytes land at consecutive buffer offsets. In standard mode the offset after 527 is 0, and a start offset above 527 begins at 0.
- R6: In binary mode the offset after 511 is 0.
- R7: A rise of chip select after all three address bytes (with zero or more data bytes) raises `busy_o` within 4 clocks. When the sequence ends, the page holds the full buffer contents, including bytes written by earlier frames.
- R8: A rise of chip select before the third address byte is complete starts no sequence.
- R9: `busy_o` stays high for exactly 2×page + ERASE_TAIL + PROG_TAIL clocks. A frame that begins while busy is ignored entirely: it causes no buffer write and no new sequence.
- R10: Bits are taken MSB first on rising SCK while chip select is low. A partial byte at the rise of chip select is dropped.
- R11: Once the erase phase has finished, every page byte that the program phase has not yet reached reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are oversampled |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_mode_bin | input | 1 | Static page geometry: 0 = 528-byte, 1 = 512-byte |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI serial data in |
| busy_o | output | 1 | High while the erase/program sequence runs |
| peek_page | input | $clog2(NUM_PAGES) | Array page to observe |
| peek_idx | input | 10 | Byte offset to observe |
| peek_data | output | 8 | Array byte at peek_page/peek_idx |

## Verification
A corrupted buffer pointer shows up as array bytes at the wrong offsets. This appears on the peek port as soon as the next sequence ends, because every commit copies the whole page. A decoder stuck in the wrong state shows up in one of two ways: `busy_o` fails to rise within a few clocks of chip select going high, or it rises for a frame that should have been dropped. A wrong sequencer count changes the length of the busy window to the exact clock. A skipped erase phase is caught in the middle of the window by reading a not-yet-programmed byte that should be 0xFF.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  localparam logic [7:0] OPC_BUF_A = 8'h82;
  localparam logic [7:0] OPC_BUF_B = 8'h85;
  localparam int PAGE_STD  = 528;
  localparam int PAGE_BIN  = 512;
  localparam int PTR_W     = 10;

  typedef enum logic [2:0] {
    D_OPC, D_AD0, D_AD1, D_AD2, D_DATA, D_SKIP
  } dec_state_t;

  typedef enum logic [2:0] {
    Q_IDLE, Q_ERASE, Q_ETAIL, Q_PROG, Q_PTAIL
  } seq_state_t;
endpackage

// File: rtl/sfb_spi_rx.sv
module sfb_spi_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       byte_vld,
  output logic [7:0] byte_dat,
  output logic       cs_fall,
  output logic       cs_rise
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sck_sy, cs_sy, mosi_sy;
  logic         sck_d, cs_d;
  logic [2:0]   bit_cnt, bit_cnt_n;
  logic [6:0]   shreg, shreg_n;
  logic         sck_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      cs_sy   <= '1;
      mosi_sy <= '0;
      sck_d   <= 1'b0;
      cs_d    <= 1'b1;
    end else begin
      sck_sy  <= {sck_sy[TOP-1:0], spi_sck};
      cs_sy   <= {cs_sy[TOP-1:0], spi_cs_n};
      mosi_sy <= {mosi_sy[TOP-1:0], spi_mosi};
      sck_d   <= sck_sy[TOP];
      cs_d    <= cs_sy[TOP];
    end
  end

  assign sck_rise = sck_sy[TOP] & ~sck_d;
  assign cs_fall  = cs_d & ~cs_sy[TOP];
  assign cs_rise  = ~cs_d & cs_sy[TOP];

  always_comb begin
    bit_cnt_n = bit_cnt;
    shreg_n   = shreg;
    byte_vld  = 1'b0;
    byte_dat  = {shreg, mosi_sy[TOP]};
    if (cs_sy[TOP]) begin
      bit_cnt_n = '0;
    end else if (sck_rise) begin
      shreg_n   = {shreg[5:0], mosi_sy[TOP]};
      bit_cnt_n = bit_cnt + 3'd1;
      byte_vld  = (bit_cnt == 3'd7);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else begin
      bit_cnt <= bit_cnt_n;
      shreg   <= shreg_n;
    end
  end
endmodule

// File: rtl/sfb_cmd_dec.sv
module sfb_cmd_dec
  import sfb_pkg::*;
#(
  parameter int NUM_PAGES = 2,
  parameter int PIDX_W    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bin_mode,
  input  logic              busy,
  input  logic              byte_vld,
  input  logic [7:0]        byte_dat,
  input  logic              cs_fall,
  input  logic              cs_rise,
  output logic              buf_we,
  output logic              buf_sel,
  output logic [PTR_W-1:0]  buf_ptr,
  output logic [7:0]        buf_wdat,
  output logic              commit,
  output logic [PIDX_W-1:0] commit_pidx,
  output logic              commit_buf
);
  dec_state_t        st, st_n;
  logic              sel, sel_n;
  logic [14:0]       ahi, ahi_n;
  logic [PTR_W-1:0]  ptr, ptr_n;
  logic [PIDX_W-1:0] pidx, pidx_n;
  logic [22:0]       full_addr;
  logic [12:0]       page_num;
  logic [PTR_W-1:0]  bfa, last;

  assign full_addr = {ahi, byte_dat};
  assign page_num  = bin_mode ? full_addr[21:9] : full_addr[22:10];
  assign bfa       = bin_mode ? {1'b0, full_addr[8:0]} : full_addr[9:0];
  assign last      = bin_mode ? PTR_W'(PAGE_BIN - 1) : PTR_W'(PAGE_STD - 1);

  always_comb begin
    st_n   = st;
    sel_n  = sel;
    ahi_n  = ahi;
    ptr_n  = ptr;
    pidx_n = pidx;
    buf_we = 1'b0;
    commit = 1'b0;
    if (cs_fall) begin
      st_n = busy ? D_SKIP : D_OPC;
    end else if (cs_rise) begin
      commit = (st == D_DATA);
      st_n   = D_OPC;
    end else if (byte_vld) begin
      case (st)
        D_OPC: begin
          if (!busy && (byte_dat == OPC_BUF_A || byte_dat == OPC_BUF_B)) begin
            sel_n = (byte_dat == OPC_BUF_B);
            st_n  = D_AD0;
          end else begin
            st_n = D_SKIP;
          end
        end
        D_AD0: begin
          ahi_n[14:8] = byte_dat[6:0];
          st_n        = D_AD1;
        end
        D_AD1: begin
          ahi_n[7:0] = byte_dat;
          st_n       = D_AD2;
        end
        D_AD2: begin
          pidx_n = PIDX_W'(page_num % 13'(NUM_PAGES));
          ptr_n  = (bfa > last) ? '0 : bfa;
          st_n   = D_DATA;
        end
        D_DATA: begin
          buf_we = 1'b1;
          ptr_n  = (ptr >= last) ? '0 : ptr + PTR_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= D_OPC;
      sel  <= 1'b0;
      ahi  <= '0;
      ptr  <= '0;
      pidx <= '0;
    end else begin
      st   <= st_n;
      sel  <= sel_n;
      ahi  <= ahi_n;
      ptr  <= ptr_n;
      pidx <= pidx_n;
    end
  end

  assign buf_sel     = sel;
  assign buf_ptr     = ptr;
  assign buf_wdat    = byte_dat;
  assign commit_pidx = pidx;
  assign commit_buf  = sel;
endmodule

// File: rtl/sfb_prog_seq.sv
module sfb_prog_seq
  import sfb_pkg::*;
#(
  parameter int PIDX_W     = 1,
  parameter int ERASE_TAIL = 16,
  parameter int PROG_TAIL  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bin_mode,
  input  logic              commit,
  input  logic [PIDX_W-1:0] commit_pidx,
  input  logic              commit_buf,
  output logic              busy,
  output logic              arr_we,
  output logic [PIDX_W-1:0] arr_pidx,
  output logic [PTR_W-1:0]  arr_idx,
  output logic [7:0]        arr_wdat,
  output logic              rd_buf,
  input  logic [7:0]        rd_dat
);
  localparam int TMAX  = (ERASE_TAIL > PROG_TAIL) ? ERASE_TAIL : PROG_TAIL;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int CNT_W = (TW > PTR_W) ? TW : PTR_W;

  seq_state_t        st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [PIDX_W-1:0] pidx, pidx_n;
  logic              bsel, bsel_n;
  logic [CNT_W-1:0]  last;

  assign last = bin_mode ? CNT_W'(PAGE_BIN - 1) : CNT_W'(PAGE_STD - 1);

  always_comb begin
    st_n     = st;
    cnt_n    = cnt;
    pidx_n   = pidx;
    bsel_n   = bsel;
    arr_we   = 1'b0;
    arr_wdat = 8'hFF;
    case (st)
      Q_IDLE: if (commit) begin
        st_n   = Q_ERASE;
        cnt_n  = '0;
        pidx_n = commit_pidx;
        bsel_n = commit_buf;
      end
      Q_ERASE: begin
        arr_we = 1'b1;
        if (cnt == last) begin
          cnt_n = '0;
          st_n  = Q_ETAIL;
        end else cnt_n = cnt + CNT_W'(1);
      end
      Q_ETAIL: begin
        if (cnt == CNT_W'(ERASE_TAIL - 1)) begin
          cnt_n = '0;
          st_n  = Q_PROG;
        end else cnt_n = cnt + CNT_W'(1);
      end
      Q_PROG: begin
        arr_we   = 1'b1;
        arr_wdat = rd_dat;
        if (cnt == last) begin
          cnt_n = '0;
          st_n  = Q_PTAIL;
        end else cnt_n = cnt + CNT_W'(1);
      end
      Q_PTAIL: begin
        if (cnt == CNT_W'(PROG_TAIL - 1)) begin
          cnt_n = '0;
          st_n  = Q_IDLE;
        end else cnt_n = cnt + CNT_W'(1);
      end
      default: st_n = Q_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= Q_IDLE;
      cnt  <= '0;
      pidx <= '0;
      bsel <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      pidx <= pidx_n;
      bsel <= bsel_n;
    end
  end

  assign busy     = (st != Q_IDLE);
  assign arr_pidx = pidx;
  assign arr_idx  = cnt[PTR_W-1:0];
  assign rd_buf   = bsel;
endmodule

// File: rtl/sfb_store.sv
module sfb_store
  import sfb_pkg::*;
#(
  parameter int NUM_PAGES = 2,
  parameter int PIDX_W    = 1
) (
  input  logic              clk,
  input  logic              buf_we,
  input  logic              buf_sel,
  input  logic [PTR_W-1:0]  buf_ptr,
  input  logic [7:0]        buf_wdat,
  input  logic              rd_buf,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [7:0]        rd_dat,
  input  logic              arr_we,
  input  logic [PIDX_W-1:0] arr_pidx,
  input  logic [PTR_W-1:0]  arr_idx,
  input  logic [7:0]        arr_wdat,
  input  logic [PIDX_W-1:0] peek_page,
  input  logic [PTR_W-1:0]  peek_idx,
  output logic [7:0]        peek_data
);
  logic [7:0] bufm [2][PAGE_STD];
  logic [7:0] arr  [NUM_PAGES][PAGE_STD];

  always_ff @(posedge clk) begin
    if (buf_we) bufm[buf_sel][buf_ptr] <= buf_wdat;
  end

  always_ff @(posedge clk) begin
    if (arr_we) arr[arr_pidx][arr_idx] <= arr_wdat;
  end

  assign rd_dat    = bufm[rd_buf][rd_idx];
  assign peek_data = arr[peek_page][peek_idx];
endmodule

// File: rtl/sflash_bufprog_engine.sv
module sflash_bufprog_engine
  import sfb_pkg::*;
#(
  parameter int NUM_PAGES   = 2,
  parameter int ERASE_TAIL  = 16,
  parameter int PROG_TAIL   = 16,
  parameter int SYNC_STAGES = 2,
  localparam int PIDX_W     = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_mode_bin,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              busy_o,
  input  logic [PIDX_W-1:0] peek_page,
  input  logic [PTR_W-1:0]  peek_idx,
  output logic [7:0]        peek_data
);
  logic              byte_vld, cs_fall, cs_rise;
  logic [7:0]        byte_dat;
  logic              buf_we, buf_sel, commit, commit_buf;
  logic [PTR_W-1:0]  buf_ptr;
  logic [7:0]        buf_wdat;
  logic [PIDX_W-1:0] commit_pidx, arr_pidx;
  logic              arr_we, rd_buf;
  logic [PTR_W-1:0]  arr_idx;
  logic [7:0]        arr_wdat, rd_dat;

  sfb_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) rx_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .cs_fall(cs_fall), .cs_rise(cs_rise)
  );

  sfb_cmd_dec #(.NUM_PAGES(NUM_PAGES), .PIDX_W(PIDX_W)) dec_i (
    .clk(clk), .rst_n(rst_n), .bin_mode(page_mode_bin), .busy(busy_o),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .buf_we(buf_we), .buf_sel(buf_sel),
    .buf_ptr(buf_ptr), .buf_wdat(buf_wdat), .commit(commit),
    .commit_pidx(commit_pidx), .commit_buf(commit_buf)
  );

  sfb_prog_seq #(.PIDX_W(PIDX_W), .ERASE_TAIL(ERASE_TAIL),
                 .PROG_TAIL(PROG_TAIL)) seq_i (
    .clk(clk), .rst_n(rst_n), .bin_mode(page_mode_bin), .commit(commit),
    .commit_pidx(commit_pidx), .commit_buf(commit_buf), .busy(busy_o),
    .arr_we(arr_we), .arr_pidx(arr_pidx), .arr_idx(arr_idx),
    .arr_wdat(arr_wdat), .rd_buf(rd_buf), .rd_dat(rd_dat)
  );

  sfb_store #(.NUM_PAGES(NUM_PAGES), .PIDX_W(PIDX_W)) store_i (
    .clk(clk), .buf_we(buf_we), .buf_sel(buf_sel), .buf_ptr(buf_ptr),
    .buf_wdat(buf_wdat), .rd_buf(rd_buf), .rd_idx(arr_idx),
    .rd_dat(rd_dat), .arr_we(arr_we), .arr_pidx(arr_pidx),
    .arr_idx(arr_idx), .arr_wdat(arr_wdat), .peek_page(peek_page),
    .peek_idx(peek_idx), .peek_data(peek_data)
  );
endmodule

// File: rtl/sfb_checker.sv
module sfb_checker #(
  parameter int ERASE_TAIL = 16,
  parameter int PROG_TAIL  = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bin_mode,
  input logic       busy,
  input logic       commit,
  input logic       buf_we,
  input logic [9:0] buf_ptr
);
  logic [15:0] run_cnt;
  logic [15:0] exp_len;
  logic [9:0]  last_loc;

  assign exp_len  = bin_mode ? 16'(2 * 512 + ERASE_TAIL + PROG_TAIL)
                             : 16'(2 * 528 + ERASE_TAIL + PROG_TAIL);
  assign last_loc = bin_mode ? 10'd511 : 10'd527;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else        run_cnt <= busy ? run_cnt + 16'd1 : '0;
  end

  p_commit_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);

  p_no_commit_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !commit);

  p_no_bufwr_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !busy);

  p_ptr_in_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (buf_ptr <= last_loc));

  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == exp_len));
endmodule

bind sflash_bufprog_engine sfb_checker #(
  .ERASE_TAIL(ERASE_TAIL), .PROG_TAIL(PROG_TAIL)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bin_mode(page_mode_bin), .busy(busy_o),
  .commit(commit), .buf_we(buf_we), .buf_ptr(buf_ptr)
);

// File: tb/sflash_bufprog_engine_tb_top.sv
`timescale 1ns/1ps
module sflash_bufprog_engine_tb_top;
  localparam int ET = 16;
  localparam int PT = 16;
  localparam int LEN_STD = 2 * 528 + ET + PT;
  localparam int LEN_BIN = 2 * 512 + ET + PT;

  logic       clk, rst_n, mode, sck, csn, mosi;
  logic       busy;
  logic [0:0] peek_page;
  logic [9:0] peek_idx;
  logic [7:0] peek_data;
  int n_chk, n_fail;
  bit done;

  sflash_bufprog_engine #(.NUM_PAGES(2), .ERASE_TAIL(ET), .PROG_TAIL(PT),
                          .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .page_mode_bin(mode), .spi_sck(sck),
    .spi_cs_n(csn), .spi_mosi(mosi), .busy_o(busy),
    .peek_page(peek_page), .peek_idx(peek_idx), .peek_data(peek_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic peek_chk(input string tag, input int pg, input int idx, input int exp);
    @(negedge clk);
    peek_page = 1'(pg);
    peek_idx  = 10'(idx);
    #1;
    chk(tag, int'(peek_data), exp);
  endtask

  task automatic spi_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = b[i];
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    @(negedge clk);
    csn = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (4) @(negedge clk);
    csn = 1'b1;
  endtask

  task automatic header(input logic [7:0] opc, input logic [23:0] a);
    cs_lo();
    spi_bits(opc, 8);
    spi_bits(a[23:16], 8);
    spi_bits(a[15:8], 8);
    spi_bits(a[7:0], 8);
  endtask

  // Chip select rises; check busy rises and lasts the expected window
  task automatic commit_timed(input string tag, input int exp_len);
    int n;
    cs_hi();
    n = 0;
    repeat (8) begin @(negedge clk); n++; end
    chk({tag, " R7 busy after commit"}, int'(busy), 1);
    while (busy && n < exp_len + 100) begin @(negedge clk); n++; end
    chk({tag, " R9 busy window"}, int'(n >= exp_len + 2 && n <= exp_len + 4), 1);
  endtask

  task automatic idle_wait(input string tag, input int cyc);
    repeat (cyc) @(negedge clk);
    chk({tag, " busy stays low"}, int'(busy), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
  endtask

  task automatic t_std_basic();
    header(8'h82, 24'h800405);  // R3: bit 23 set, page 1, offset 5
    spi_bits(8'hA0, 8); spi_bits(8'hA1, 8); spi_bits(8'hA2, 8);
    commit_timed("std", LEN_STD);
    peek_chk("R3 page1[5]", 1, 5, 'hA0);
    peek_chk("R10 page1[6]", 1, 6, 'hA1);
    peek_chk("R3 page1[7]", 1, 7, 'hA2);
  endtask

  task automatic t_std_wrap();
    header(8'h82, 24'h00020E);  // page 0, offset 526
    spi_bits(8'h11, 8); spi_bits(8'h22, 8); spi_bits(8'h33, 8); spi_bits(8'h44, 8);
    commit_timed("wrap", LEN_STD);
    peek_chk("R5 page0[526]", 0, 526, 'h11);
    peek_chk("R5 page0[527]", 0, 527, 'h22);
    peek_chk("R5 page0[0]", 0, 0, 'h33);
    peek_chk("R5 page0[1]", 0, 1, 'h44);
    peek_chk("R7 retained page0[5]", 0, 5, 'hA0);
  endtask

  task automatic t_two_bufs();
    header(8'h85, 24'h000005);
    spi_bits(8'h5A, 8);
    commit_timed("bufB", LEN_STD);
    peek_chk("R2 buffer2 page0[5]", 0, 5, 'h5A);
    header(8'h82, 24'h000000);
    commit_timed("bufA", LEN_STD);
    peek_chk("R2 buffer1 intact page0[5]", 0, 5, 'hA0);
  endtask

  task automatic t_abort();
    cs_lo();
    spi_bits(8'h82, 8); spi_bits(8'h00, 8); spi_bits(8'h00, 8);
    spi_bits(8'h00, 5);
    cs_hi();
    idle_wait("R8 short address", 40);
  endtask

  task automatic t_bad_opc();
    header(8'h84, 24'h000005);
    spi_bits(8'h77, 8);
    cs_hi();
    idle_wait("R2 unknown opcode", 40);
    header(8'h82, 24'h000000);
    commit_timed("after bad", LEN_STD);
    peek_chk("R2 no write by unknown opcode", 0, 5, 'hA0);
  endtask

  task automatic t_busy_ignore();
    int n;
    header(8'h82, 24'h000400);  // page 1, no data
    cs_hi();
    repeat (10) @(negedge clk);
    header(8'h82, 24'h000005);   // issued while busy
    spi_bits(8'hEE, 8);
    cs_hi();
    n = 0;
    while (busy && n < 4000) begin @(negedge clk); n++; end
    repeat (20) @(negedge clk);
    chk("R9 no retrigger", int'(busy), 0);
    peek_chk("R9 page0 untouched", 0, 5, 'hA0);
    header(8'h82, 24'h000000);
    commit_timed("post busy", LEN_STD);
    peek_chk("R9 buffer not written while busy", 0, 5, 'hA0);
  endtask

  task automatic t_partial();
    header(8'h82, 24'h000405);
    spi_bits(8'hC1, 8);
    spi_bits(8'h3C, 5);
    commit_timed("partial", LEN_STD);
    peek_chk("R10 full byte kept", 1, 5, 'hC1);
    peek_chk("R10 partial byte dropped", 1, 6, 'hA1);
  endtask

  task automatic t_bin();
    mode = 1'b1;
    header(8'h82, 24'hC003FE);  // R4: bits 23..22 set, page 1, offset 510
    spi_bits(8'h31, 8); spi_bits(8'h32, 8); spi_bits(8'h33, 8); spi_bits(8'h34, 8);
    commit_timed("bin", LEN_BIN);
    peek_chk("R6 page1[510]", 1, 510, 'h31);
    peek_chk("R6 page1[511]", 1, 511, 'h32);
    peek_chk("R4 page1[0]", 1, 0, 'h33);
    peek_chk("R6 page1[1]", 1, 1, 'h34);
  endtask

  task automatic t_erase();
    int n;
    header(8'h82, 24'h000200);  // binary page 1, no data
    cs_hi();
    repeat (3 + 512 + ET + 256) @(negedge clk);
    peek_page = 1'b1;
    peek_idx  = 10'd511;
    #1;
    chk("R11 erased before program", int'(peek_data), 'hFF);
    n = 0;
    while (busy && n < 4000) begin @(negedge clk); n++; end
    peek_chk("R11 programmed after", 1, 511, 'h32);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; mode = 1'b0; sck = 1'b0; csn = 1'b1; mosi = 1'b0;
    peek_page = '0; peek_idx = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_std_basic();
    t_std_wrap();
    t_two_bufs();
    t_abort();
    t_bad_opc();
    t_busy_ignore();
    t_partial();
    t_bin();
    t_erase();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule